// File: doc/BRIEF.md
# MOESI Line Probe Response Controller

This block is the snoop side of one line in a private cache that keeps MOESI coherence. Forwarded requests from other caches arrive on a valid/ready channel. Each request is decoded into an event and applied to the line's stable or transient state. The block then answers the requester with either a control acknowledgement or a data response, and pops the request. A plain invalidate probe is handled the same way as a remote read-for-ownership.

A second input reports that all acknowledgements for a miss have arrived. When the line settles in a shared state, the block sends the home directory a shared-kind unblock. When it settles in a modified state, it sends an owned/exclusive-kind unblock. The processor side is reduced to three inputs: a load port that forces the line state and dirty bit, a verify-fill pulse that merges an incoming dirty flag, and the all-acks trigger. Both outgoing channels are single-entry holding registers with valid/ready handshakes.

Top module: `moesi_probe_ctrl`

## Requirements
- R1: The probe type field codes are: 0 remote read-exclusive, 1 remote read-shared, 2 remote read-shared without migration, 3 invalidate, 4 writeback ack, 5 writeback nack, and 6 or 7 unused. A writeback ack or nack is consumed with no probe response, and the cycle after the handshake it pulses `wb_ack_o` or `wb_nack_o`. Codes 6 and 7 are consumed with no effect.
- R2: In S (state code 1), a read-exclusive or an invalidate sends an ACK and moves the line to I (0). A read-shared of either kind sends an ACK and leaves the state at S.
- R3: Responses in O (2), M (3) and MM (4):
  - In O, any probe sends DATA. A read-exclusive or invalidate moves the line to I; a read-shared of either kind leaves it in O.
  - In M, a read-exclusive or invalidate sends DATA_EX and moves the line to I. A read-shared of either kind sends DATA and moves the line to O.
  - In MM, a read-exclusive, an invalidate or a migratory read-shared sends DATA_EX and moves the line to I. A read-shared without migration sends DATA and moves the line to O.
- R4: A DATA or DATA_EX response carries an ack count of NUM_CACHES when the probe was directed, and 2 otherwise. An ACK response always carries a count of 1. A directed probe that would be answered with an ACK is a protocol error and fires an assertion.
- R5: In IT, ST, OT, MT, MMT (16 to 20), and in the waiting states ISM (9), SS (10), MM_W (11) and M_W (12), a probe with a type code from 0 to 3 is stalled. `probe_ready_o` stays low and the request is neither dropped nor answered.
- R6: In I (0), IM (5), IS (8) and II (15), every probe type from 0 to 3 is answered with an ACK, and the state does not change.
- R7: In SM (6), a read-exclusive or invalidate sends an ACK and moves the line to IM. A read-shared leaves SM and sends an ACK. In OM (7), a read-exclusive or invalidate sends DATA, moves the line to IM and increments `pend_cnt_o`. A read-shared sends DATA and leaves OM.
- R8: In OI (13) or MI (14), a read-exclusive or invalidate sends DATA from the writeback copy and moves the line to II. A read-shared sends DATA and keeps the state. Every data response carries the line's dirty bit from before the handshake edge.
- R9: An accepted all-acks trigger moves the line and sends an unblock to HOME_ID as follows:
  - ISM with no sharers moves to MM and sends UNBLOCK_M.
  - OM, whatever the sharer flag, moves to MM and sends UNBLOCK_M.
  - SS, whatever the sharer flag, moves to S and sends UNBLOCK_S.
  - MM_W with no sharers moves to MM and sends UNBLOCK_M.
  - M_W with no sharers moves to M and sends UNBLOCK_M.
  - Every other case is consumed with no effect.
- R10: A verify-fill pulse sets the dirty bit to the OR of the incoming flag and the current bit, so a clean fill never clears a dirty line.
- R11: At most one probe is accepted per cycle. The ready signals follow these rules:
  - `probe_ready_o` is high only when no load is pending, the probe is not stalled, and the response register is empty or draining.
  - `trig_ready_o` additionally requires that no probe is accepted in the same cycle, and that the unblock register is empty or draining.
  - A load overrides the state and dirty bit and clears `pend_cnt_o`.
  - A held response keeps its fields stable.
  - Reset leaves the line in I, clean, with both channels empty.
- R12: The response type codes are ACK 0, DATA 1, DATA_EX 2, UNBLOCK_S 3 and UNBLOCK_M 4. A probe response is addressed to the probe's source ID, and an unblock is addressed to HOME_ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | Force line state and dirty bit |
| load_state_i | input | 5 | State code to load |
| load_dirty_i | input | 1 | Dirty bit to load |
| fill_valid_i | input | 1 | Verify-fill pulse |
| fill_dirty_i | input | 1 | Dirty flag of the verify fill |
| probe_valid_i | input | 1 | Forwarded request valid |
| probe_ready_o | output | 1 | Forwarded request popped |
| probe_type_i | input | 3 | Request type code |
| probe_directed_i | input | 1 | Probe was directed, not broadcast |
| probe_src_i | input | ID_W | Requester ID |
| trig_valid_i | input | 1 | All acks received |
| trig_ready_o | output | 1 | Trigger accepted |
| trig_no_sharers_i | input | 1 | No sharers were reported |
| resp_valid_o | output | 1 | Probe response valid |
| resp_ready_i | input | 1 | Probe response taken |
| resp_type_o | output | 3 | Response type code |
| resp_acks_o | output | ACK_W | Expected-ack count |
| resp_dest_o | output | ID_W | Response destination |
| resp_dirty_o | output | 1 | Dirty flag carried with data |
| ublk_valid_o | output | 1 | Unblock valid |
| ublk_ready_i | input | 1 | Unblock taken |
| ublk_type_o | output | 3 | Unblock kind code |
| ublk_dest_o | output | ID_W | Home directory ID |
| wb_ack_o | output | 1 | Writeback ack event pulse |
| wb_nack_o | output | 1 | Writeback nack event pulse |
| line_state_o | output | 5 | Current line state code |
| line_dirty_o | output | 1 | Current dirty bit |
| pend_cnt_o | output | CNT_W | Outstanding message count |

## Verification
The assertions are checked on every cycle and cover the following:
- a stalled probe is never popped;
- a directed probe never draws an ACK;
- ACK counts are fixed at 1, and data counts are one of the two legal values;
- held responses stay stable;
- a dirty fill makes the bit sticky;
- SS always unblocks with the shared kind;
- I, IM, IS and II do not move on a probe.

Only the bench's reference model can show the full transition and response table:
- the interaction of a load, a probe and a trigger in the same cycle;
- the dirty value latched into a data response;
- the OM outstanding-count increment;
- writeback event pulses under random backpressure on both output channels.

// File: rtl/moesi_probe_pkg.sv
package moesi_probe_pkg;

  typedef enum logic [4:0] {
    ST_I   = 5'd0,  ST_S   = 5'd1,  ST_O  = 5'd2,  ST_M   = 5'd3,
    ST_MM  = 5'd4,  ST_IM  = 5'd5,  ST_SM = 5'd6,  ST_OM  = 5'd7,
    ST_IS  = 5'd8,  ST_ISM = 5'd9,  ST_SS = 5'd10, ST_MMW = 5'd11,
    ST_MW  = 5'd12, ST_OI  = 5'd13, ST_MI = 5'd14, ST_II  = 5'd15,
    ST_IT  = 5'd16, ST_ST  = 5'd17, ST_OT = 5'd18, ST_MT  = 5'd19,
    ST_MMT = 5'd20
  } line_st_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_RD_EX, EV_RD_SH, EV_RD_SH_NM, EV_INVAL, EV_WB_ACK, EV_WB_NACK
  } probe_ev_e;

  typedef enum logic [2:0] {
    RS_ACK = 3'd0, RS_DATA = 3'd1, RS_DATA_EX = 3'd2,
    RS_UNBLK_S = 3'd3, RS_UNBLK_M = 3'd4
  } rsp_e;

  function automatic logic probe_blocked(line_st_e s);
    return s inside {ST_ISM, ST_SS, ST_MMW, ST_MW,
                     ST_IT, ST_ST, ST_OT, ST_MT, ST_MMT};
  endfunction

endpackage

// File: rtl/moesi_probe_decode.sv
module moesi_probe_decode
  import moesi_probe_pkg::*;
(
  input  logic [2:0] ptype_i,
  output probe_ev_e  ev_o
);
  always_comb begin
    unique case (ptype_i)
      3'd0:    ev_o = EV_RD_EX;
      3'd1:    ev_o = EV_RD_SH;
      3'd2:    ev_o = EV_RD_SH_NM;
      3'd3:    ev_o = EV_INVAL;
      3'd4:    ev_o = EV_WB_ACK;
      3'd5:    ev_o = EV_WB_NACK;
      default: ev_o = EV_NONE;
    endcase
  end
endmodule

// File: rtl/moesi_probe_fsm.sv
module moesi_probe_fsm
  import moesi_probe_pkg::*;
(
  input  line_st_e  st_i,
  input  probe_ev_e ev_i,
  output line_st_e  nxt_o,
  output logic      send_o,
  output rsp_e      kind_o,
  output logic      pend_inc_o,
  output logic      stall_o
);
  logic kill, is_probe;

  assign kill     = (ev_i == EV_RD_EX) || (ev_i == EV_INVAL);
  assign is_probe = kill || (ev_i == EV_RD_SH) || (ev_i == EV_RD_SH_NM);
  assign stall_o  = is_probe && probe_blocked(st_i);

  always_comb begin
    nxt_o      = st_i;
    send_o     = 1'b0;
    kind_o     = RS_ACK;
    pend_inc_o = 1'b0;
    if (is_probe && !stall_o) begin
      send_o = 1'b1;
      unique case (st_i)
        ST_S: if (kill) nxt_o = ST_I;
        ST_SM: if (kill) nxt_o = ST_IM;
        ST_O: begin
          kind_o = RS_DATA;
          if (kill) nxt_o = ST_I;
        end
        ST_M: begin
          kind_o = kill ? RS_DATA_EX : RS_DATA;
          nxt_o  = kill ? ST_I : ST_O;
        end
        ST_MM: begin
          // migratory: plain read-shared takes ownership away
          if (kill || ev_i == EV_RD_SH) begin
            kind_o = RS_DATA_EX;
            nxt_o  = ST_I;
          end else begin
            kind_o = RS_DATA;
            nxt_o  = ST_O;
          end
        end
        ST_OM: begin
          kind_o = RS_DATA;
          if (kill) begin
            nxt_o      = ST_IM;
            pend_inc_o = 1'b1;
          end
        end
        ST_OI, ST_MI: begin
          kind_o = RS_DATA;
          if (kill) nxt_o = ST_II;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_trig_fsm.sv
module moesi_trig_fsm
  import moesi_probe_pkg::*;
(
  input  line_st_e st_i,
  input  logic     no_sh_i,
  output line_st_e nxt_o,
  output logic     send_o,
  output rsp_e     kind_o
);
  always_comb begin
    nxt_o  = st_i;
    send_o = 1'b0;
    kind_o = RS_UNBLK_M;
    unique case (st_i)
      ST_ISM: if (no_sh_i) begin nxt_o = ST_MM; send_o = 1'b1; end
      ST_OM:  begin nxt_o = ST_MM; send_o = 1'b1; end
      ST_SS:  begin nxt_o = ST_S; send_o = 1'b1; kind_o = RS_UNBLK_S; end
      ST_MMW: if (no_sh_i) begin nxt_o = ST_MM; send_o = 1'b1; end
      ST_MW:  if (no_sh_i) begin nxt_o = ST_M; send_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_out_reg.sv
module moesi_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/moesi_probe_ctrl.sv
module moesi_probe_ctrl
  import moesi_probe_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ID_W       = 3,
  parameter int ACK_W      = 4,
  parameter int CNT_W      = 4,
  parameter int HOME_ID    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_valid_i,
  input  logic [4:0]       load_state_i,
  input  logic             load_dirty_i,
  input  logic             fill_valid_i,
  input  logic             fill_dirty_i,
  input  logic             probe_valid_i,
  output logic             probe_ready_o,
  input  logic [2:0]       probe_type_i,
  input  logic             probe_directed_i,
  input  logic [ID_W-1:0]  probe_src_i,
  input  logic             trig_valid_i,
  output logic             trig_ready_o,
  input  logic             trig_no_sharers_i,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [2:0]       resp_type_o,
  output logic [ACK_W-1:0] resp_acks_o,
  output logic [ID_W-1:0]  resp_dest_o,
  output logic             resp_dirty_o,
  output logic             ublk_valid_o,
  input  logic             ublk_ready_i,
  output logic [2:0]       ublk_type_o,
  output logic [ID_W-1:0]  ublk_dest_o,
  output logic             wb_ack_o,
  output logic             wb_nack_o,
  output logic [4:0]       line_state_o,
  output logic             line_dirty_o,
  output logic [CNT_W-1:0] pend_cnt_o
);
  localparam int RSP_W  = 3 + ACK_W + ID_W + 1;
  localparam int UBLK_W = 3 + ID_W;
  localparam logic [ACK_W-1:0] ACKS_DIR  = ACK_W'(NUM_CACHES);
  localparam logic [ACK_W-1:0] ACKS_BC   = ACK_W'(2);
  localparam logic [ACK_W-1:0] ACKS_CTRL = ACK_W'(1);

  line_st_e   st_q, p_nxt, t_nxt;
  probe_ev_e  ev;
  rsp_e       p_kind, t_kind;
  logic       p_send, p_pend, p_stall, t_send;
  logic       p_fire, t_fire, rsp_free, ublk_free;
  logic       dirty_q;
  logic [CNT_W-1:0] pend_q;
  logic [ACK_W-1:0] acks;
  logic [RSP_W-1:0]  rsp_d, rsp_q;
  logic [UBLK_W-1:0] ublk_d, ublk_q;

  moesi_probe_decode u_dec (.ptype_i(probe_type_i), .ev_o(ev));

  moesi_probe_fsm u_pfsm (
    .st_i(st_q), .ev_i(ev), .nxt_o(p_nxt), .send_o(p_send),
    .kind_o(p_kind), .pend_inc_o(p_pend), .stall_o(p_stall)
  );

  moesi_trig_fsm u_tfsm (
    .st_i(st_q), .no_sh_i(trig_no_sharers_i),
    .nxt_o(t_nxt), .send_o(t_send), .kind_o(t_kind)
  );

  assign probe_ready_o = !load_valid_i && !p_stall && rsp_free;
  assign p_fire        = probe_valid_i && probe_ready_o;
  assign trig_ready_o  = !load_valid_i && !p_fire && ublk_free;
  assign t_fire        = trig_valid_i && trig_ready_o;

  always_comb begin
    if (p_kind == RS_ACK)    acks = ACKS_CTRL;
    else if (probe_directed_i) acks = ACKS_DIR;
    else                     acks = ACKS_BC;
  end

  assign rsp_d  = {p_kind, acks, probe_src_i, dirty_q};
  assign ublk_d = {t_kind, ID_W'(HOME_ID)};

  moesi_out_reg #(.W(RSP_W)) u_rsp (
    .clk_i, .rst_ni, .load_i(p_fire && p_send), .data_i(rsp_d),
    .ready_i(resp_ready_i), .valid_o(resp_valid_o), .data_o(rsp_q),
    .free_o(rsp_free)
  );

  moesi_out_reg #(.W(UBLK_W)) u_ublk (
    .clk_i, .rst_ni, .load_i(t_fire && t_send), .data_i(ublk_d),
    .ready_i(ublk_ready_i), .valid_o(ublk_valid_o), .data_o(ublk_q),
    .free_o(ublk_free)
  );

  assign {resp_type_o, resp_acks_o, resp_dest_o, resp_dirty_o} = rsp_q;
  assign {ublk_type_o, ublk_dest_o} = ublk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_I;
      dirty_q   <= 1'b0;
      pend_q    <= '0;
      wb_ack_o  <= 1'b0;
      wb_nack_o <= 1'b0;
    end else begin
      wb_ack_o  <= p_fire && (ev == EV_WB_ACK);
      wb_nack_o <= p_fire && (ev == EV_WB_NACK);
      if (load_valid_i) begin
        st_q    <= line_st_e'(load_state_i);
        dirty_q <= load_dirty_i;
        pend_q  <= '0;
      end else begin
        if (p_fire && p_send)      st_q <= p_nxt;
        else if (t_fire && t_send) st_q <= t_nxt;
        if (fill_valid_i)          dirty_q <= dirty_q | fill_dirty_i;
        if (p_fire && p_pend)      pend_q <= pend_q + 1'b1;
      end
    end
  end

  assign line_state_o = st_q;
  assign line_dirty_o = dirty_q;
  assign pend_cnt_o   = pend_q;

endmodule

// File: rtl/moesi_probe_ctrl_chk.sv
module moesi_probe_ctrl_chk
  import moesi_probe_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ID_W       = 3,
  parameter int ACK_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_valid_i,
  input logic             fill_valid_i,
  input logic             fill_dirty_i,
  input logic             probe_valid_i,
  input logic             probe_ready_o,
  input logic [2:0]       probe_type_i,
  input logic             probe_directed_i,
  input logic             trig_valid_i,
  input logic             trig_ready_o,
  input logic             resp_valid_o,
  input logic             resp_ready_i,
  input logic [2:0]       resp_type_o,
  input logic [ACK_W-1:0] resp_acks_o,
  input logic [ID_W-1:0]  resp_dest_o,
  input logic             ublk_valid_o,
  input logic [2:0]       ublk_type_o,
  input logic [4:0]       line_state_o,
  input logic             line_dirty_o
);
  logic real_probe, p_fire, st_blk, st_ackonly;
  assign real_probe = probe_type_i < 3'd4;
  assign p_fire     = probe_valid_i && probe_ready_o;
  assign st_blk     = probe_blocked(line_st_e'(line_state_o));
  assign st_ackonly = line_state_o inside {ST_I, ST_IM, ST_IS, ST_II};

  AST_STALL_KEEPS_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i && real_probe && st_blk |-> !probe_ready_o); // R5

  AST_DIRECTED_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_fire && real_probe && probe_directed_i |=> resp_valid_o && resp_type_o != RS_ACK); // R4

  AST_ACK_COUNT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_type_o == RS_ACK |-> resp_acks_o == ACK_W'(1)); // R4

  AST_DATA_COUNT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_type_o inside {RS_DATA, RS_DATA_EX}
    |-> resp_acks_o == ACK_W'(2) || resp_acks_o == ACK_W'(NUM_CACHES)); // R4

  AST_RESP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_type_o)
    && $stable(resp_acks_o) && $stable(resp_dest_o)); // R11

  AST_DIRTY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_i && fill_valid_i && fill_dirty_i |=> line_dirty_o); // R10

  AST_SS_UNBLOCK_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_valid_i && trig_ready_o && line_state_o == ST_SS
    |=> ublk_valid_o && ublk_type_o == RS_UNBLK_S); // R9

  AST_ACKONLY_STATE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_fire && real_probe && st_ackonly |=> $stable(line_state_o)); // R6

endmodule

bind moesi_probe_ctrl moesi_probe_ctrl_chk #(
  .NUM_CACHES(NUM_CACHES), .ID_W(ID_W), .ACK_W(ACK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_valid_i(load_valid_i),
  .fill_valid_i(fill_valid_i), .fill_dirty_i(fill_dirty_i),
  .probe_valid_i(probe_valid_i), .probe_ready_o(probe_ready_o),
  .probe_type_i(probe_type_i), .probe_directed_i(probe_directed_i),
  .trig_valid_i(trig_valid_i), .trig_ready_o(trig_ready_o),
  .resp_valid_o(resp_valid_o), .resp_ready_i(resp_ready_i),
  .resp_type_o(resp_type_o), .resp_acks_o(resp_acks_o),
  .resp_dest_o(resp_dest_o), .ublk_valid_o(ublk_valid_o),
  .ublk_type_o(ublk_type_o), .line_state_o(line_state_o),
  .line_dirty_o(line_dirty_o)
);

// File: tb/moesi_probe_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_probe_ctrl_tb_top;
  localparam int NC = 4, IDW = 3, AW = 4, CW = 4, HOME = 7;

  logic clk = 1'b0;
  logic rst_ni;
  always #2 clk = ~clk;

  logic load_valid, load_dirty, fill_valid, fill_dirty;
  logic [4:0] load_state;
  logic probe_valid, probe_ready, probe_dir;
  logic [2:0] probe_type;
  logic [IDW-1:0] probe_src;
  logic trig_valid, trig_ready, trig_nosh;
  logic resp_valid, resp_ready, resp_dirty;
  logic [2:0] resp_type;
  logic [AW-1:0] resp_acks;
  logic [IDW-1:0] resp_dest;
  logic ublk_valid, ublk_ready;
  logic [2:0] ublk_type;
  logic [IDW-1:0] ublk_dest;
  logic wb_ack, wb_nack, line_dirty;
  logic [4:0] line_state;
  logic [CW-1:0] pend_cnt;

  moesi_probe_ctrl #(.NUM_CACHES(NC), .ID_W(IDW), .ACK_W(AW), .CNT_W(CW), .HOME_ID(HOME)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .load_valid_i(load_valid), .load_state_i(load_state), .load_dirty_i(load_dirty),
    .fill_valid_i(fill_valid), .fill_dirty_i(fill_dirty),
    .probe_valid_i(probe_valid), .probe_ready_o(probe_ready), .probe_type_i(probe_type),
    .probe_directed_i(probe_dir), .probe_src_i(probe_src),
    .trig_valid_i(trig_valid), .trig_ready_o(trig_ready), .trig_no_sharers_i(trig_nosh),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready), .resp_type_o(resp_type),
    .resp_acks_o(resp_acks), .resp_dest_o(resp_dest), .resp_dirty_o(resp_dirty),
    .ublk_valid_o(ublk_valid), .ublk_ready_i(ublk_ready), .ublk_type_o(ublk_type),
    .ublk_dest_o(ublk_dest), .wb_ack_o(wb_ack), .wb_nack_o(wb_nack),
    .line_state_o(line_state), .line_dirty_o(line_dirty), .pend_cnt_o(pend_cnt)
  );

  // reference model state
  int ms, mp, mrt, mra, mrd, mut;
  bit md, mrv, mrdirty, muv, mwa, mwn;
  bit exp_prdy, exp_trdy;
  string st_tag, rs_tag;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit blocked(int s, int pt);
    return pt < 4 && (s inside {[9:12], [16:20]});
  endfunction

  function automatic bit data_state(int s);
    return s inside {2, 3, 4, 7, 13, 14};
  endfunction

  task automatic send(int kind, string tag);
    mrv = 1; mrt = kind; mrd = int'(probe_src); mrdirty = md; rs_tag = tag;
    mra = (kind == 0) ? 1 : (probe_dir ? NC : 2);
  endtask

  task automatic model_probe(int pt);
    bit x = (pt == 0 || pt == 3);
    st_tag = "R6";
    case (ms)
      0, 5, 8, 15: send(0, "R6");
      1: begin send(0, "R2"); st_tag = "R2"; if (x) ms = 0; end
      6: begin send(0, "R7"); st_tag = "R7"; if (x) ms = 5; end
      2: begin send(1, "R3"); st_tag = "R3"; if (x) ms = 0; end
      3: begin st_tag = "R3"; send(x ? 2 : 1, "R3"); ms = x ? 0 : 2; end
      4: begin
        st_tag = "R3";
        if (x || pt == 1) begin send(2, "R3"); ms = 0; end
        else begin send(1, "R3"); ms = 2; end
      end
      7: begin send(1, "R7"); st_tag = "R7"; if (x) begin ms = 5; mp = (mp + 1) % 16; end end
      13, 14: begin send(1, "R8"); st_tag = "R8"; if (x) ms = 15; end
      default: ;
    endcase
  endtask

  task automatic model_trig();
    case (ms)
      9:  if (trig_nosh) begin ms = 4; muv = 1; mut = 4; end
      7:  begin ms = 4; muv = 1; mut = 4; end
      10: begin ms = 1; muv = 1; mut = 3; end
      11: if (trig_nosh) begin ms = 4; muv = 1; mut = 4; end
      12: if (trig_nosh) begin ms = 3; muv = 1; mut = 4; end
      default: ;
    endcase
    st_tag = "R9";
  endtask

  task automatic model_step();
    bit pf = probe_valid && exp_prdy;
    bit tf = trig_valid && exp_trdy;
    if (mrv && resp_ready) mrv = 0;
    if (muv && ublk_ready) muv = 0;
    mwa = 0; mwn = 0;
    if (pf) begin
      if (probe_type == 4) mwa = 1;
      else if (probe_type == 5) mwn = 1;
      else if (probe_type < 4) model_probe(int'(probe_type));
    end
    if (tf) model_trig();
    if (load_valid) begin
      ms = int'(load_state); md = load_dirty; mp = 0; st_tag = "R11";
    end else if (fill_valid) md = md | fill_dirty;
  endtask

  task automatic compare_regs();
    chk(int'(line_state) == ms, st_tag, "state", int'(line_state), ms);
    chk(line_dirty == md, "R10", "dirty", line_dirty, md);
    chk(int'(pend_cnt) == mp, "R7", "pend_cnt", int'(pend_cnt), mp);
    chk(wb_ack == mwa, "R1", "wb_ack", wb_ack, mwa);
    chk(wb_nack == mwn, "R1", "wb_nack", wb_nack, mwn);
    chk(resp_valid == mrv, "R11", "resp_valid", resp_valid, mrv);
    if (mrv && resp_valid) begin
      chk(int'(resp_type) == mrt, rs_tag, "resp_type", int'(resp_type), mrt);
      chk(int'(resp_acks) == mra, "R4", "resp_acks", int'(resp_acks), mra);
      chk(int'(resp_dest) == mrd, "R12", "resp_dest", int'(resp_dest), mrd);
      chk(resp_dirty == mrdirty, "R8", "resp_dirty", resp_dirty, mrdirty);
    end
    chk(ublk_valid == muv, "R9", "ublk_valid", ublk_valid, muv);
    if (muv && ublk_valid) begin
      chk(int'(ublk_type) == mut, "R9", "ublk_type", int'(ublk_type), mut);
      chk(int'(ublk_dest) == HOME, "R12", "ublk_dest", int'(ublk_dest), HOME);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    {load_valid, load_dirty, fill_valid, fill_dirty, probe_valid, probe_dir, trig_valid, trig_nosh} = '0;
    load_state = '0; probe_type = '0; probe_src = '0;
    resp_ready = 1; ublk_ready = 1;
    ms = 0; mp = 0; md = 0; mrv = 0; muv = 0; mwa = 0; mwn = 0;
    mrt = 0; mra = 0; mrd = 0; mut = 0; mrdirty = 0;
    st_tag = "R11"; rs_tag = "R11";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    compare_regs(); // R11 reset state
    for (int i = 0; i < 8000; i++) begin
      if (i > 0) begin
        @(negedge clk);
        compare_regs();
      end
      load_valid = ($urandom % 8) == 0;
      load_state = 5'($urandom % 21);
      load_dirty = 1'($urandom);
      fill_valid = ($urandom % 6) == 0;
      fill_dirty = 1'($urandom);
      probe_valid = ($urandom % 3) != 0;
      probe_type = 3'($urandom);
      probe_src = IDW'($urandom);
      // directed probes only where a data answer is due (R4)
      probe_dir = !load_valid && data_state(ms) && 1'($urandom);
      trig_valid = ($urandom % 3) == 0;
      trig_nosh = 1'($urandom);
      resp_ready = ($urandom % 4) != 0;
      ublk_ready = ($urandom % 3) != 0;
      #1;
      exp_prdy = !load_valid && !blocked(ms, int'(probe_type)) && (!mrv || resp_ready);
      exp_trdy = !load_valid && !(probe_valid && exp_prdy) && (!muv || ublk_ready);
      chk(probe_ready == exp_prdy, blocked(ms, int'(probe_type)) ? "R5" : "R11",
          "probe_ready", probe_ready, exp_prdy);
      chk(trig_ready == exp_trdy, "R11", "trig_ready", trig_ready, exp_trdy);
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    compare_regs();
    done = 1;
    summary();
    $finish;
  end
endmodule